// File: doc/BRIEF.md
# Masked Privileged Control Register File

This block holds a bank of 64-bit privileged control registers for a processor core. It has one read port and one write port, each addressed by a 6-bit register index. Writes do not land as plain storage. Each register applies its own keep-mask to the written data, or clears itself on any write, or refuses the write. Writes to read-only registers, reads of write-only registers and accesses to unassigned indices raise a single-cycle fault strobe in the same cycle as the request.

One register gives a combined view of time. Its upper half is stored, and its lower half is a free-running 32-bit cycle counter. Two write-only invalidate controls send a one-cycle pulse to a neighbouring translation buffer. When the core is executing speculatively, it raises a suppress input that discards writes along with any fault they would raise. Reset loads zero everywhere, except for three registers: machine control, firmware base and the id scratch register.

Index map:
- 0..7: scratch registers, full width. Index 7 is the id scratch register.
- 8: firmware base.
- 9: machine control.
- 10: exception PC.
- 11, 12: trap request and trap enable.
- 13: interrupt level.
- 14, 15: instruction mode and data mode.
- 16: software request.
- 17: interrupt control.
- 18, 19: instruction and data page-table base.
- 20: cache test.
- 21, 22: cache mode 0 and cache mode 1.
- 23, 24: instruction and data address-space id.
- 25, 26: exception summary and exception mask.
- 27: time register.
- 28..31: read-only.
- 32: invalidate-all.
- 33: invalidate-process.
- 34: alternate mode.
- 35: flush.
- 36..63: unassigned.

Top module: `ctlreg_bank`

## Requirements
- R1: Reset behaviour.
  - Every register reads as zero after reset, with three exceptions.
  - Index 9 reads 0x6.
  - Index 8 reads the FW_BASE_RST parameter.
  - Index 7 reads the `cpu_id_i` value, zero-extended.
  - The cycle counter restarts at zero.
- R2: Indices 0..9 store all 64 written bits.
- R3: A write to index 10 stores the data with bit 1 forced to zero.
- R4: Writes keep only the masked bits:
  - indices 11 and 12: mask 0xf
  - index 13: mask 0x1f
  - indices 14 and 15: mask 0x18
  - index 16: mask 0x7fff0
  - index 17: mask 0xffffff0300
  - indices 18 and 19: mask 0xffffffffc0000000
  - index 20: mask 0x1ffb
  - indices 21 and 22: mask 0x3f
  - index 23: mask 0x7f0
  - index 24: mask 0xfe00000000000000
- R5: Any write to index 25 or 26 clears that register to zero, whatever the data.
- R6: A write to a read-only index (28..31) raises `fault_o` and leaves the register unchanged. Reading these indices raises no fault.
- R7: A read of a write-only index (32..35) returns zero and raises `fault_o`. A write to these indices raises no fault.
- R8: Any access to an index from 36 to 63 raises `fault_o`, and a read of such an index returns zero.
- R9: A read of index 27 returns the stored bits [63:32] joined with a 32-bit counter. The counter counts clock edges since reset release.
- R10: While `spec_i` is high, writes change nothing, pulse nothing and raise no fault.
- R11: A write to index 32 gives a one-cycle pulse on `inv_all_o` in the following cycle. A write to index 33 does the same on `inv_proc_o`.
- R12: Read data is combinational. A read and a write to the same index in the same cycle return the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_id_i | input | CIDW | Value loaded into index 7 at reset |
| spec_i | input | 1 | Speculative: suppress writes and write faults |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | IDW | Read index |
| rd_data_o | output | 64 | Read data (zero when not reading) |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | IDW | Write index |
| wr_data_i | input | 64 | Write data |
| fault_o | output | 1 | Access fault, same cycle as the request |
| inv_all_o | output | 1 | Invalidate-all pulse to the translation buffer |
| inv_proc_o | output | 1 | Invalidate-process pulse to the translation buffer |

## Verification
The assertions check several rules in every cycle:
- the exception-PC and interrupt-level read-back shape;
- zero data and a fault on write-only reads;
- no fault while suppressed unless a read is pending;
- clear-on-write of the exception summary;
- that each invalidate pulse follows a matching unsuppressed write.

Only the bench scenarios can show the per-register masks across random data and the reset values. They also cover the live counter value in the time register, the old-value return when a read and a write collide, and the fact that suppressed writes leave stored state untouched.

// File: rtl/ctlreg_bank.sv
module ctlreg_bank #(
  parameter int IDW = 6,
  parameter int CIDW = 8,
  parameter logic [63:0] FW_BASE_RST = 64'h0000_0000_0040_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CIDW-1:0] cpu_id_i,
  input  logic            spec_i,
  input  logic            rd_en_i,
  input  logic [IDW-1:0]  rd_idx_i,
  output logic [63:0]     rd_data_o,
  input  logic            wr_en_i,
  input  logic [IDW-1:0]  wr_idx_i,
  input  logic [63:0]     wr_data_i,
  output logic            fault_o,
  output logic            inv_all_o,
  output logic            inv_proc_o
);
  localparam int NREG = 32;
  localparam int I_SCR_ID = 7, I_BASE = 8, I_MCTL = 9, I_CYC = 27;
  localparam int I_FLA = 32, I_FLP = 33;

  typedef enum logic [2:0] {K_RW, K_CLR, K_RO, K_WOA, K_WOP, K_WO, K_BAD} kind_t;

  function automatic kind_t kind_of(int i);
    if (i <= 24 || i == I_CYC) return K_RW;
    if (i == 25 || i == 26) return K_CLR;
    if (i >= 28 && i <= 31) return K_RO;
    if (i == I_FLA) return K_WOA;
    if (i == I_FLP) return K_WOP;
    if (i == 34 || i == 35) return K_WO;
    return K_BAD;
  endfunction

  function automatic logic [63:0] keep_of(int i);
    case (i)
      10:      return ~64'h2;
      11, 12:  return 64'hf;
      13:      return 64'h1f;
      14, 15:  return 64'h18;
      16:      return 64'h7fff0;
      17:      return 64'hff_ffff_0300;
      18, 19:  return 64'hffff_ffff_c000_0000;
      20:      return 64'h1ffb;
      21, 22:  return 64'h3f;
      23:      return 64'h7f0;
      24:      return 64'hfe00_0000_0000_0000;
      default: return '1;
    endcase
  endfunction

  logic [63:0] regs [NREG];
  logic [31:0] cnt;
  kind_t rk, wk;
  logic wr_go;

  assign rk = kind_of(int'(rd_idx_i));
  assign wk = kind_of(int'(wr_idx_i));
  assign wr_go = wr_en_i && !spec_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      regs[I_SCR_ID] <= 64'(cpu_id_i);
      regs[I_BASE]   <= FW_BASE_RST;
      regs[I_MCTL]   <= 64'h6;
    end else if (wr_go) begin
      if (wk == K_RW)  regs[wr_idx_i[4:0]] <= wr_data_i & keep_of(int'(wr_idx_i));
      if (wk == K_CLR) regs[wr_idx_i[4:0]] <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      inv_all_o <= 1'b0;
      inv_proc_o <= 1'b0;
    end else begin
      cnt <= cnt + 32'd1;
      inv_all_o <= wr_go && wk == K_WOA;
      inv_proc_o <= wr_go && wk == K_WOP;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i && (rk == K_RW || rk == K_CLR || rk == K_RO)) begin
      rd_data_o = regs[rd_idx_i[4:0]];
      if (int'(rd_idx_i) == I_CYC) rd_data_o[31:0] = cnt;
    end
  end

  assign fault_o = (rd_en_i && (rk == K_WOA || rk == K_WOP || rk == K_WO || rk == K_BAD)) ||
                   (wr_go && (wk == K_RO || wk == K_BAD));
endmodule

module ctlreg_bank_chk #(parameter int IDW = 6) (
  input logic           clk,
  input logic           rst_n,
  input logic           spec_i,
  input logic           rd_en_i,
  input logic [IDW-1:0] rd_idx_i,
  input logic [63:0]    rd_data_o,
  input logic           wr_en_i,
  input logic [IDW-1:0] wr_idx_i,
  input logic           fault_o,
  input logic           inv_all_o,
  input logic           inv_proc_o
);
  assert_epc_bit1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && int'(rd_idx_i) == 10 |-> rd_data_o[1] == 1'b0);
  assert_level_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && int'(rd_idx_i) == 13 |-> rd_data_o[63:5] == '0);
  assert_wo_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && int'(rd_idx_i) >= 32 && int'(rd_idx_i) <= 35 |-> rd_data_o == '0 && fault_o);
  assert_spec_nofault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    spec_i && !rd_en_i |-> !fault_o);
  assert_xsum_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !spec_i && int'(wr_idx_i) == 25 |=>
      !(rd_en_i && int'(rd_idx_i) == 25) || rd_data_o == '0);
  assert_inv_all_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all_o |-> $past(wr_en_i && !spec_i && int'(wr_idx_i) == 32));
  assert_inv_proc_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_proc_o |-> $past(wr_en_i && !spec_i && int'(wr_idx_i) == 33));
  assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(inv_all_o && inv_proc_o));
endmodule

bind ctlreg_bank ctlreg_bank_chk #(.IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .spec_i(spec_i), .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i),
  .rd_data_o(rd_data_o), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .fault_o(fault_o),
  .inv_all_o(inv_all_o), .inv_proc_o(inv_proc_o));

// File: tb/sim_ctlreg_bank.sv
`timescale 1ns/1ps
module sim_ctlreg_bank;
  localparam logic [63:0] FWB = 64'h0000_0000_0040_0000;
  logic clk = 0, rst_n = 0, spec_i = 0, rd_en_i = 0, wr_en_i = 0;
  logic [7:0] cpu_id_i = 8'h5A;
  logic [5:0] rd_idx_i = 0, wr_idx_i = 0;
  logic [63:0] wr_data_i = 0, rd_data_o;
  logic fault_o, inv_all_o, inv_proc_o;
  int vec = 0, bad = 0;
  logic [63:0] m [32];
  logic [31:0] cyc = 0;
  bit pa = 0, pp = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= rst_n ? cyc + 32'd1 : 32'd0;

  ctlreg_bank u0 (.clk, .rst_n, .cpu_id_i, .spec_i, .rd_en_i, .rd_idx_i, .rd_data_o,
    .wr_en_i, .wr_idx_i, .wr_data_i, .fault_o, .inv_all_o, .inv_proc_o);

  // kinds: 0 rw, 1 clear, 2 read-only, 3 inv-all, 4 inv-proc, 5 write-only, 6 unassigned
  function automatic int bkind(int i);
    if (i <= 24 || i == 27) return 0;
    if (i == 25 || i == 26) return 1;
    if (i >= 28 && i <= 31) return 2;
    if (i == 32) return 3;
    if (i == 33) return 4;
    if (i == 34 || i == 35) return 5;
    return 6;
  endfunction

  function automatic logic [63:0] bmask(int i);
    if (i == 10) return 64'hffff_ffff_ffff_fffd;
    if (i == 11 || i == 12) return 64'hf;
    if (i == 13) return 64'h1f;
    if (i == 14 || i == 15) return 64'h18;
    if (i == 16) return 64'h7fff0;
    if (i == 17) return 64'hff_ffff_0300;
    if (i == 18 || i == 19) return 64'hffff_ffff_c000_0000;
    if (i == 20) return 64'h1ffb;
    if (i == 21 || i == 22) return 64'h3f;
    if (i == 23) return 64'h7f0;
    if (i == 24) return 64'hfe00_0000_0000_0000;
    return '1;
  endfunction

  function automatic string tag_of(int i);
    case (bkind(i))
      0: return i == 10 ? "R3" : i == 27 ? "R9" : i <= 9 ? "R2" : "R4";
      1: return "R5";
      2: return "R6";
      6: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit re, int ri, bit we, int wi, logic [63:0] wd, bit sp);
    logic [63:0] er;
    bit ef;
    int k;
    string t;
    rd_en_i = re; rd_idx_i = 6'(ri); wr_en_i = we; wr_idx_i = 6'(wi);
    wr_data_i = wd; spec_i = sp;
    #1;
    er = '0;
    k = bkind(ri);
    if (re && k <= 2) begin
      er = m[ri];
      if (ri == 27) er[31:0] = cyc;
    end
    ef = (re && k >= 3) || (we && !sp && (bkind(wi) == 2 || bkind(wi) == 6));
    t = (re && we && ri == wi) ? "R12" : tag_of(ri);
    if (re) chk(rd_data_o == er, t, "read", rd_data_o, er);
    t = (we && sp) ? "R10" : we ? tag_of(wi) : tag_of(ri);
    chk(fault_o == ef, t, "fault", 64'(fault_o), 64'(ef));
    chk(inv_all_o == pa, "R11", "inv_all", 64'(inv_all_o), 64'(pa));
    chk(inv_proc_o == pp, "R11", "inv_proc", 64'(inv_proc_o), 64'(pp));
    pa = we && !sp && wi == 32;
    pp = we && !sp && wi == 33;
    @(posedge clk);
    if (we && !sp && wi < 32) begin
      if (bkind(wi) == 0) m[wi] = wd & bmask(wi);
      if (bkind(wi) == 1) m[wi] = '0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) m[i] = '0;
    m[7] = 64'h5A; m[8] = FWB; m[9] = 64'h6;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    for (int i = 0; i < 32; i++) step(1, i, 0, 0, 0, 0);
    chk(u0.rd_data_o == rd_data_o, "R1", "sanity", 0, 0);
    // R3, R4, R5 directed
    step(0, 0, 1, 10, '1, 0);
    step(1, 10, 0, 0, 0, 0);
    step(0, 0, 1, 13, '1, 0);
    step(1, 13, 0, 0, 0, 0);
    step(0, 0, 1, 25, '1, 0);
    step(1, 25, 0, 0, 0, 0);
    // R6 read-only write, R8 unassigned
    step(0, 0, 1, 29, '1, 0);
    step(1, 29, 1, 50, '1, 0);
    step(1, 63, 0, 0, 0, 0);
    // R10 suppressed writes
    step(0, 0, 1, 3, 64'hDEAD_BEEF_0000_1111, 1);
    step(1, 3, 1, 28, '1, 1);
    step(0, 0, 1, 32, 0, 1);
    step(1, 3, 0, 0, 0, 0);
    // R11 pulses
    step(0, 0, 1, 32, 0, 0);
    step(0, 0, 1, 33, 0, 0);
    step(1, 32, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // R12 collision, R9 time register
    step(1, 4, 1, 4, 64'h1234_5678_9ABC_DEF0, 0);
    step(1, 4, 0, 0, 0, 0);
    step(0, 0, 1, 27, 64'hCAFE_F00D_FFFF_FFFF, 0);
    step(1, 27, 0, 0, 0, 0);
    step(1, 27, 0, 0, 0, 0);
    for (int n = 0; n < 4000; n++) begin
      step(1'($urandom_range(0, 1)), $urandom_range(0, 40),
           1'($urandom_range(0, 1)), $urandom_range(0, 40),
           {$urandom, $urandom}, $urandom_range(0, 9) == 0);
    end
    step(0, 0, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule